// File: doc/BRIEF.md
# Microcoded Single-Bus Processor Datapath

This block is a small 32-bit processor in which every register transfer crosses one shared 32-bit data bus. Four sources can drive the bus: the register file, the ALU, the immediate extender and the memory read port. Latches A and B feed the ALU, MA holds the memory address and IR holds the current instruction. A horizontal microword drives the bus enables and the register loads in each cycle. The microword is read from a microcode ROM that is indexed by a microprogram counter.

The register file has 33 entries. Entries 0 to 31 are the general registers and entry 32 is the program counter, so the program counter is incremented by the same bus write path as any other register. A fetch microroutine reads the instruction and advances the program counter. A dispatch function then maps the opcode to the first microstate of a three-step routine. Each routine loads A, loads B, writes the result back and returns to fetch.

Every register write is shown on a trace port, so a testbench or a neighbouring block can follow the architectural state.

Top module: `ubus_cpu`

## Requirements
- R1: After reset the first microstate drives neither a memory read nor a register write. The first instruction is read from address RESET_PC (default 0). The program counter resets to RESET_PC and general registers 0 to 31 reset to zero.
- R2: In any cycle at most one of the four bus sources is enabled. A write to a register carries the value that the enabled source puts on the bus.
- R3: Fetch takes four microstates, in this order: MA gets PC, A gets PC, IR gets memory, PC gets A+4. The program-counter write (index 32) shows on the trace port in the cycle after the instruction read completes. Its value is the fetched address plus 4.
- R4: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and imm [15:0]. The register-register opcodes are 0x01 (add), 0x02 (subtract, rs minus rt) and 0x03 (bitwise OR). Each writes rs op rt into rd.
- R5: There are three register-immediate opcodes, and each writes its result into rt. 0x08 adds the sign-extended imm to rs. 0x0D ORs the zero-extended imm into rs. 0x0F ORs imm shifted left by 16 into rs.
- R6: Opcode 0x11 writes into register 31 the already-incremented PC plus the sign-extended imm.
- R7: While mem_busy is high the microstate holds and no register, latch or IR is loaded. A read with wait states gives the same results as one without, and each wait cycle adds one cycle to the instruction.
- R8: An opcode with no routine writes only the program counter. Execution then continues with the instruction at the next word address.
- R9: With no wait states, each known instruction takes 7 cycles from one instruction read to the next. An unknown opcode takes 4 cycles.
- R10: A register that has not been written since reset reads as zero when it is used as an operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Memory address, taken from MA |
| mem_rd | output | 1 | Memory read; memory drives the bus this cycle |
| mem_wr | output | 1 | Memory write strobe from the microword |
| mem_wdata | output | 32 | Bus value offered as write data |
| mem_rdata | input | 32 | Memory read data |
| mem_busy | input | 1 | Memory not ready; microstate holds |
| wb_valid | output | 1 | A register write takes effect at the next rising edge |
| wb_idx | output | 6 | Index of the register being written (32 is the PC) |
| wb_data | output | 32 | Value being written |

## Verification
The assertions assume that mem_busy rises only during a memory read. They also assume that mem_rdata is stable during the cycle in which the read completes. The IR check compares IR with the data seen in that cycle. The stall check assumes that every hold comes from mem_busy. The memory model in the testbench raises busy only while mem_rd is high, keeps it high for a fixed number of cycles, and returns word data indexed by mem_addr. This keeps the stimulus within those assumptions. All programs use only the defined encodings, plus one deliberately undefined opcode.

// File: rtl/ubus_pkg.sv
package ubus_pkg;

   localparam int UPC_W    = 5;
   localparam int RIDX_W   = 6;
   localparam int GPR_N    = 32;
   localparam int RF_N     = GPR_N + 1;
   localparam int PC_IDX   = GPR_N;
   localparam int LINK_IDX = GPR_N - 1;
   localparam int UC_DEPTH = 25;

   typedef enum logic [2:0] {
      SEL_RS, SEL_RT, SEL_RD, SEL_PC, SEL_LINK
   } rsel_e;

   typedef enum logic [1:0] {
      ALU_ADD, ALU_SUB, ALU_OR, ALU_INC4
   } alu_op_e;

   typedef enum logic [1:0] {
      EXT_SIGN, EXT_ZERO, EXT_HIGH, EXT_RSVD
   } ext_e;

   typedef enum logic [1:0] {
      SQ_NEXT, SQ_DISPATCH, SQ_FETCH
   } seq_e;

   typedef struct packed {
      rsel_e   reg_sel;
      logic    reg_en;
      logic    reg_wr;
      logic    alu_en;
      logic    mem_en;
      logic    imm_en;
      logic    ld_a;
      logic    ld_b;
      logic    ld_ma;
      logic    ld_ir;
      logic    mem_wr;
      ext_e    ext_sel;
      alu_op_e alu_op;
      seq_e    seq;
   } uword_t;

   localparam logic [5:0] OP_RADD  = 6'h01;
   localparam logic [5:0] OP_RSUB  = 6'h02;
   localparam logic [5:0] OP_ROR   = 6'h03;
   localparam logic [5:0] OP_ADDI  = 6'h08;
   localparam logic [5:0] OP_ORI   = 6'h0D;
   localparam logic [5:0] OP_ORHI  = 6'h0F;
   localparam logic [5:0] OP_LINKI = 6'h11;

   localparam logic [UPC_W-1:0] UA_FETCH = 5'd0;
   localparam logic [UPC_W-1:0] UA_RADD  = 5'd4;
   localparam logic [UPC_W-1:0] UA_RSUB  = 5'd7;
   localparam logic [UPC_W-1:0] UA_ROR   = 5'd10;
   localparam logic [UPC_W-1:0] UA_ADDI  = 5'd13;
   localparam logic [UPC_W-1:0] UA_ORI   = 5'd16;
   localparam logic [UPC_W-1:0] UA_ORHI  = 5'd19;
   localparam logic [UPC_W-1:0] UA_LINKI = 5'd22;

   function automatic logic [UPC_W-1:0] dispatch(input logic [5:0] op);
      case (op)
         OP_RADD:  return UA_RADD;
         OP_RSUB:  return UA_RSUB;
         OP_ROR:   return UA_ROR;
         OP_ADDI:  return UA_ADDI;
         OP_ORI:   return UA_ORI;
         OP_ORHI:  return UA_ORHI;
         OP_LINKI: return UA_LINKI;
         default:  return UA_FETCH;
      endcase
   endfunction

endpackage

// File: rtl/ubus_alu.sv
module ubus_alu
   import ubus_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  alu_op_e           op,
   output logic [DATA_W-1:0] res
);

   localparam logic [DATA_W-1:0] STEP = DATA_W'(4);

   always_comb begin
      case (op)
         ALU_ADD:  res = opa + opb;
         ALU_SUB:  res = opa - opb;
         ALU_OR:   res = opa | opb;
         ALU_INC4: res = opa + STEP;
         default:  res = '0;
      endcase
   end

endmodule

// File: rtl/ubus_immx.sv
module ubus_immx
   import ubus_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [IMM_W-1:0]  imm,
   input  ext_e              mode,
   output logic [DATA_W-1:0] ext
);

   localparam int PAD_W = DATA_W - IMM_W;

   always_comb begin
      case (mode)
         EXT_SIGN: ext = {{PAD_W{imm[IMM_W-1]}}, imm};
         EXT_ZERO: ext = {{PAD_W{1'b0}}, imm};
         EXT_HIGH: ext = {imm, {PAD_W{1'b0}}};
         default:  ext = {{PAD_W{1'b0}}, imm};
      endcase
   end

endmodule

// File: rtl/ubus_rf.sv
module ubus_rf
   import ubus_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter logic [DATA_W-1:0] RESET_PC = '0,
   parameter bit                RF_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rsel_e             sel,
   input  logic [4:0]        f_rs,
   input  logic [4:0]        f_rt,
   input  logic [4:0]        f_rd,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [RIDX_W-1:0] idx
);

   logic [DATA_W-1:0] view [RF_N];

   always_comb begin
      case (sel)
         SEL_RS:   idx = {1'b0, f_rs};
         SEL_RT:   idx = {1'b0, f_rt};
         SEL_RD:   idx = {1'b0, f_rd};
         SEL_PC:   idx = RIDX_W'(PC_IDX);
         SEL_LINK: idx = RIDX_W'(LINK_IDX);
         default:  idx = RIDX_W'(PC_IDX);
      endcase
   end

   for (genvar i = 0; i < RF_N; i++) begin : g_ent
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = we && (idx == RIDX_W'(i));
      if (i == PC_IDX) begin : g_pc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= RESET_PC;
            else if (hit) q <= wdata;
         end
      end else if (RF_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wdata;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) q <= wdata;
         end
      end
      assign view[i] = q;
   end

   assign rdata = view[idx];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> view[$past(idx)] == $past(wdata)); // R4

endmodule

// File: rtl/ubus_useq.sv
module ubus_useq
   import ubus_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stall,
   input  logic [5:0] opcode,
   output uword_t     uw
);

   logic [UPC_W-1:0] upc_q, upc_d;

   function automatic uword_t u_la(input rsel_e s);
      uword_t w = '0;
      w.reg_sel = s;
      w.reg_en  = 1'b1;
      w.ld_a    = 1'b1;
      w.seq     = SQ_NEXT;
      return w;
   endfunction

   function automatic uword_t u_lb(input rsel_e s);
      uword_t w = '0;
      w.reg_sel = s;
      w.reg_en  = 1'b1;
      w.ld_b    = 1'b1;
      w.seq     = SQ_NEXT;
      return w;
   endfunction

   function automatic uword_t u_li(input ext_e e);
      uword_t w = '0;
      w.imm_en  = 1'b1;
      w.ext_sel = e;
      w.ld_b    = 1'b1;
      w.seq     = SQ_NEXT;
      return w;
   endfunction

   function automatic uword_t u_wb(input alu_op_e op, input rsel_e s, input seq_e q);
      uword_t w = '0;
      w.alu_en  = 1'b1;
      w.alu_op  = op;
      w.reg_sel = s;
      w.reg_wr  = 1'b1;
      w.seq     = q;
      return w;
   endfunction

   always_comb begin
      uw = '0;
      case (upc_q)
         5'd0: begin
            uw.reg_sel = SEL_PC;
            uw.reg_en  = 1'b1;
            uw.ld_ma   = 1'b1;
            uw.seq     = SQ_NEXT;
         end
         5'd1: uw = u_la(SEL_PC);
         5'd2: begin
            uw.mem_en = 1'b1;
            uw.ld_ir  = 1'b1;
            uw.seq    = SQ_NEXT;
         end
         5'd3:  uw = u_wb(ALU_INC4, SEL_PC, SQ_DISPATCH);
         5'd4:  uw = u_la(SEL_RS);
         5'd5:  uw = u_lb(SEL_RT);
         5'd6:  uw = u_wb(ALU_ADD, SEL_RD, SQ_FETCH);
         5'd7:  uw = u_la(SEL_RS);
         5'd8:  uw = u_lb(SEL_RT);
         5'd9:  uw = u_wb(ALU_SUB, SEL_RD, SQ_FETCH);
         5'd10: uw = u_la(SEL_RS);
         5'd11: uw = u_lb(SEL_RT);
         5'd12: uw = u_wb(ALU_OR, SEL_RD, SQ_FETCH);
         5'd13: uw = u_la(SEL_RS);
         5'd14: uw = u_li(EXT_SIGN);
         5'd15: uw = u_wb(ALU_ADD, SEL_RT, SQ_FETCH);
         5'd16: uw = u_la(SEL_RS);
         5'd17: uw = u_li(EXT_ZERO);
         5'd18: uw = u_wb(ALU_OR, SEL_RT, SQ_FETCH);
         5'd19: uw = u_la(SEL_RS);
         5'd20: uw = u_li(EXT_HIGH);
         5'd21: uw = u_wb(ALU_OR, SEL_RT, SQ_FETCH);
         5'd22: uw = u_la(SEL_PC);
         5'd23: uw = u_li(EXT_SIGN);
         5'd24: uw = u_wb(ALU_ADD, SEL_LINK, SQ_FETCH);
         default: uw.seq = SQ_FETCH;
      endcase
   end

   always_comb begin
      if (stall) begin
         upc_d = upc_q;
      end else begin
         case (uw.seq)
            SQ_NEXT:     upc_d = upc_q + 1'b1;
            SQ_DISPATCH: upc_d = dispatch(opcode);
            default:     upc_d = UA_FETCH;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc_q <= UA_FETCH;
      else        upc_q <= upc_d;
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> upc_q == $past(upc_q)); // R7

   AST_FETCH_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (uw.seq == SQ_FETCH && !stall) |=> upc_q == UA_FETCH); // R8

   AST_UPC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      upc_q < UPC_W'(UC_DEPTH)); // R9

endmodule

// File: rtl/ubus_cpu.sv
module ubus_cpu
   import ubus_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter logic [DATA_W-1:0] RESET_PC = '0,
   parameter bit                RF_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [DATA_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_busy,
   output logic              wb_valid,
   output logic [RIDX_W-1:0] wb_idx,
   output logic [DATA_W-1:0] wb_data
);

   localparam int NSRC  = 4;
   localparam int IMM_W = 16;

   if (DATA_W != 32) begin : g_bad_width
      $error("ubus_cpu: DATA_W must be 32");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_pc
      $error("ubus_cpu: RESET_PC must be word aligned");
   end

   uword_t            uw;
   logic              stall;
   logic [DATA_W-1:0] ir_q, a_q, b_q, ma_q;
   logic [DATA_W-1:0] rf_rdata, alu_y, imm_y, bus;
   logic              rf_we;
   logic [RIDX_W-1:0] rf_idx;

   assign stall = mem_busy;
   assign mem_rd = uw.mem_en;
   assign rf_we = uw.reg_wr & ~stall;

   logic [NSRC-1:0]   drv_en;
   logic [DATA_W-1:0] drv_val [NSRC];
   logic [DATA_W-1:0] acc [NSRC+1];

   assign drv_en     = {mem_rd, uw.imm_en, uw.alu_en, uw.reg_en};
   assign drv_val[0] = rf_rdata;
   assign drv_val[1] = alu_y;
   assign drv_val[2] = imm_y;
   assign drv_val[3] = mem_rdata;
   assign acc[0]     = '0;

   for (genvar s = 0; s < NSRC; s++) begin : g_bus
      assign acc[s+1] = acc[s] | ({DATA_W{drv_en[s]}} & drv_val[s]);
   end
   assign bus = acc[NSRC];

   ubus_useq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .stall  (stall),
      .opcode (ir_q[31:26]),
      .uw     (uw)
   );

   ubus_rf #(
      .DATA_W   (DATA_W),
      .RESET_PC (RESET_PC),
      .RF_RESET (RF_RESET)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (uw.reg_sel),
      .f_rs  (ir_q[25:21]),
      .f_rt  (ir_q[20:16]),
      .f_rd  (ir_q[15:11]),
      .we    (rf_we),
      .wdata (bus),
      .rdata (rf_rdata),
      .idx   (rf_idx)
   );

   ubus_alu #(.DATA_W(DATA_W)) u_alu (
      .opa (a_q),
      .opb (b_q),
      .op  (uw.alu_op),
      .res (alu_y)
   );

   ubus_immx #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_immx (
      .imm  (ir_q[IMM_W-1:0]),
      .mode (uw.ext_sel),
      .ext  (imm_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q  <= '0;
         b_q  <= '0;
         ma_q <= '0;
         ir_q <= '0;
      end else if (!stall) begin
         if (uw.ld_a)  a_q  <= bus;
         if (uw.ld_b)  b_q  <= bus;
         if (uw.ld_ma) ma_q <= bus;
         if (uw.ld_ir) ir_q <= bus;
      end
   end

   assign mem_addr  = ma_q;
   assign mem_wr    = uw.mem_wr;
   assign mem_wdata = bus;
   assign wb_valid  = rf_we;
   assign wb_idx    = rf_idx;
   assign wb_data   = bus;

   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drv_en)); // R2

   AST_IR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (uw.ld_ir && !stall) |=> ir_q == $past(mem_rdata)); // R3

   AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ir_q == $past(ir_q)); // R7

endmodule

// File: tb/test_ubus_cpu.sv
module test_ubus_cpu;
   import ubus_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 100000;
   localparam int LOG_N      = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, wb_data;
   logic        mem_rd, mem_wr, mem_busy, wb_valid;
   logic [5:0]  wb_idx;

   logic [31:0] mem [64];
   int          lat = 0;
   int          wcnt = 0;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int gpr_n = 0, pc_n = 0, rd_n = 0, viol = 0;
   logic [5:0]  gpr_idx [LOG_N];
   logic [31:0] gpr_dat [LOG_N];
   logic [31:0] pc_dat  [LOG_N];
   int          pc_cyc  [LOG_N];
   logic [31:0] rd_addr [LOG_N];
   int          rd_cyc  [LOG_N];

   always #(CLK_PERIOD/2) clk = ~clk;

   ubus_cpu i_ubus_cpu (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_busy  (mem_busy),
      .wb_valid  (wb_valid),
      .wb_idx    (wb_idx),
      .wb_data   (wb_data)
   );

   // memory model: word array, fixed wait states per read
   assign mem_rdata = mem[mem_addr[7:2]];
   assign mem_busy  = mem_rd && (wcnt < lat);

   always @(posedge clk) begin
      if (!rst_n)                wcnt <= 0;
      else if (mem_rd && mem_busy) wcnt <= wcnt + 1;
      else                       wcnt <= 0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         cyc = cyc + 1;
         if (wb_valid && wb_idx == 6'd32) begin
            if (pc_n < LOG_N) begin
               pc_dat[pc_n] = wb_data;
               pc_cyc[pc_n] = cyc;
            end
            pc_n = pc_n + 1;
         end else if (wb_valid) begin
            if (gpr_n < LOG_N) begin
               gpr_idx[gpr_n] = wb_idx;
               gpr_dat[gpr_n] = wb_data;
            end
            gpr_n = gpr_n + 1;
         end
         if (mem_rd && !mem_busy) begin
            if (rd_n < LOG_N) begin
               rd_addr[rd_n] = mem_addr;
               rd_cyc[rd_n]  = cyc;
            end
            rd_n = rd_n + 1;
         end
         if (mem_busy && wb_valid) viol = viol + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input logic [5:0] op, input logic [4:0] rd,
                                         input logic [4:0] rs, input logic [4:0] rt);
      return {op, rs, rt, rd, 11'd0};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rt,
                                         input logic [4:0] rs, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
   endtask

   task automatic do_reset(input int l);
      @(negedge clk);
      rst_n = 1'b0;
      lat   = l;
      repeat (3) @(negedge clk);
      cyc = 0; gpr_n = 0; pc_n = 0; rd_n = 0; viol = 0;
      rst_n = 1'b1;
   endtask

   task automatic load_alu_prog();
      clear_mem();
      mem[0]  = enc_i(OP_ORI,  5'd1, 5'd0, 16'h00F0);
      mem[1]  = enc_i(OP_ORI,  5'd2, 5'd0, 16'h0013);
      mem[2]  = enc_r(OP_RADD, 5'd3, 5'd1, 5'd2);
      mem[3]  = enc_r(OP_RSUB, 5'd4, 5'd2, 5'd1);
      mem[4]  = enc_r(OP_ROR,  5'd5, 5'd1, 5'd2);
      mem[5]  = enc_i(OP_ADDI, 5'd6, 5'd1, 16'hFFFF);
      mem[6]  = enc_i(OP_ORI,  5'd7, 5'd0, 16'h8000);
      mem[7]  = enc_i(OP_ORHI, 5'd8, 5'd1, 16'h1234);
      mem[8]  = enc_r(OP_RADD, 5'd9, 5'd20, 5'd21);
      mem[9]  = enc_i(OP_LINKI, 5'd0, 5'd0, 16'h0010);
      mem[10] = {6'h3F, 26'h0};
      mem[11] = enc_i(OP_ORI,  5'd10, 5'd0, 16'h0055);
   endtask

   task automatic check_alu_log(input string tag);
      logic [5:0]  e_idx [11];
      logic [31:0] e_dat [11];
      string       rq [11];
      e_idx = '{6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9, 6'd31, 6'd10};
      e_dat = '{32'h000000F0, 32'h00000013, 32'h00000103, 32'hFFFFFF23, 32'h000000F3,
                32'h000000EF, 32'h00008000, 32'h123400F0, 32'h00000000, 32'h00000038,
                32'h00000055};
      rq = '{"R5 ori", "R5 ori", "R4 add", "R4 sub", "R4 or", "R5 addi sign",
             "R5 ori zero", "R5 orhi", "R10 unwritten operand", "R6 link", "R8 resume"};
      chk({tag, " write count"}, 32'(gpr_n), 32'd11);
      for (int k = 0; k < 11; k++) begin
         chk({tag, " ", rq[k], " idx"}, {26'd0, gpr_idx[k]}, {26'd0, e_idx[k]});
         chk({tag, " ", rq[k], " data"}, gpr_dat[k], e_dat[k]);
      end
   endtask

   task automatic t_reset();
      clear_mem();
      mem[0] = enc_r(OP_RADD, 5'd3, 5'd5, 5'd6);
      do_reset(0);
      #1;
      chk("R1 no read after reset", {31'd0, mem_rd}, 32'd0);
      chk("R1 no write after reset", {31'd0, wb_valid}, 32'd0);
      repeat (12) @(negedge clk);
      chk("R1 first read address", rd_addr[0], 32'h0);
      chk("R3 first pc write", pc_dat[0], 32'h4);
      chk("R10 reset operand idx", {26'd0, gpr_idx[0]}, 32'd3);
      chk("R10 reset operand data", gpr_dat[0], 32'h0);
   endtask

   task automatic t_alu_prog();
      load_alu_prog();
      do_reset(0);
      repeat (100) @(negedge clk);
      check_alu_log("nowait");
      for (int k = 0; k < 12; k++) begin
         chk("R3 read address", rd_addr[k], 32'(4 * k));
         chk("R3 pc value", pc_dat[k], 32'(4 * (k + 1)));
         chk("R3 pc after read", 32'(pc_cyc[k] - rd_cyc[k]), 32'd1);
      end
      chk("R9 known instr cycles", 32'(rd_cyc[1] - rd_cyc[0]), 32'd7);
      chk("R9 unknown instr cycles", 32'(rd_cyc[11] - rd_cyc[10]), 32'd4);
      chk("R8 unknown writes only pc", 32'(pc_cyc[11] - pc_cyc[10]), 32'd4);
   endtask

   task automatic t_busy();
      load_alu_prog();
      do_reset(3);
      repeat (160) @(negedge clk);
      check_alu_log("R7 wait");
      chk("R7 cycles with wait", 32'(rd_cyc[1] - rd_cyc[0]), 32'd10);
      chk("R7 unknown with wait", 32'(rd_cyc[11] - rd_cyc[10]), 32'd7);
      chk("R7 no write while busy", 32'(viol), 32'd0);
      chk("R2 pc value with wait", pc_dat[5], 32'h18);
   endtask

   initial begin
      t_reset();
      t_alu_prog();
      t_busy();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual %0d expected less", WD_CYCLES);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule